// File: doc/BRIEF.md
# Message-Write Interrupt Controller

This block collects event requests from eight internal sources and tells the host about them by posting one memory write on a bus master port. It does not drive an interrupt line. Each write carries a payload that software has programmed, and it goes to a 32-bit target address that software has also programmed. Software sets up the block through a small register slave port, which holds four words. The control word holds per-source enables, a soft reset strobe, a timeout enable, a sticky timeout flag and eight free scratch bits. The status word holds the per-source request bits and a message-sent flag. The two remaining words are the target address and the payload.

Only one message is outstanding at a time. A message goes out when an enabled request is pending, no master write is in flight, the sent flag is clear and no timeout has been recorded. After the write is acknowledged, the sent flag stays set and blocks further messages. Software services the sources and clears their request bits by writing 1 to them. Once no enabled request remains, the sent flag drops and the next enabled request raises a new message. An optional watchdog abandons a master write that waits too long for its acknowledge. It then locks the block until software issues a soft reset.

Top module: `msgirq_ctrl`

## Requirements
- R1: After reset, all four register words (control at word 0, status at word 1, target address at word 2, payload at word 3) read as zero and `mw_valid` is low.
- R2: Control bits 29:24, 12:10 and 7:0 read back as written. Bit 8 (soft reset strobe) and bit 13 (timeout flag) are not writable, and bit 8 always reads 0.
- R3: A one-cycle pulse on `evt_req[i]` sets status bit 14+i whether or not that source is enabled. The bit stays set until it is cleared. Source i is enabled by control bit 10+i for i = 0..1 and by control bit 22+i for i = 2..7.
- R4: A master write is issued when an enabled request is pending, no write is in flight, status bit 23 (sent) is clear and the timeout flag is clear. The write carries the payload word as data and the target address word as address. A source that becomes enabled while its request is already pending also triggers a write.
- R5: `mw_valid` stays high with stable `mw_addr` and `mw_data` until the cycle in which `mw_ack` is sampled high, and it is low in the following cycle.
- R6: An acknowledged write sets status bit 23. While bit 23 is set, no further write is issued, even if new enabled requests arrive.
- R7: Writing 1 to status bits 21:14 clears those request bits, and writing 0 leaves them unchanged. Bit 23 clears once no enabled request remains, and a later enabled request then issues a new write.
- R8: A request from a disabled source is recorded in status but causes no master write.
- R9: With control bit 12 set, a write that sees no acknowledge for TMO_LIMIT cycles is dropped after exactly TMO_LIMIT cycles of `mw_valid` and sets control bit 13. While bit 13 is set, no write is issued.
- R10: Writing control with bit 8 set clears all status bits and the timeout flag. The other control fields take the written value, and the target address and payload words are kept. After the soft reset, messages can be issued again.
- R11: When an event pulse and a write-1-to-clear of the same status bit arrive in the same cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | REG_AW | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, registered |
| reg_rd_valid | output | 1 | High in the cycle after a read strobe |
| evt_req | input | 8 | Per-source event pulses |
| mw_valid | output | 1 | Master write request |
| mw_addr | output | 32 | Master write address |
| mw_data | output | 32 | Master write data |
| mw_ack | input | 1 | Master write acknowledge |

## Verification
The assertions assume that `mw_ack` is raised only while `mw_valid` is high, and that a soft reset is the only event besides an acknowledge or a timeout that may end a pending write. The bench raises the acknowledge only after it has seen `mw_valid` high, holds it for exactly one cycle, and never issues a soft reset while a write is waiting. It also assumes that register strobes and event pulses change only between clock edges. All stimulus is driven on the falling edge to satisfy that.

// File: rtl/msgirq_pkg.sv
package msgirq_pkg;
  localparam int NSRC       = 8;
  localparam int REQ_LSB    = 14;
  localparam int SENT_BIT   = 23;
  localparam int TMO_FLAG   = 13;
  localparam int TMO_EN     = 12;
  localparam int SRST_BIT   = 8;
  localparam int SCR_W      = 8;

  typedef enum logic [1:0] {
    W_CTRL  = 2'd0,
    W_STAT  = 2'd1,
    W_TADDR = 2'd2,
    W_PLOAD = 2'd3
  } reg_word_e;

  typedef enum logic {
    SND_IDLE = 1'b0,
    SND_WAIT = 1'b1
  } snd_state_e;

  // control bit that enables source i
  function automatic int en_pos(input int i);
    return (i < 2) ? (10 + i) : (22 + i);
  endfunction

  function automatic logic [31:0] ctrl_wmask();
    logic [31:0] m;
    m = '0;
    for (int i = 0; i < NSRC; i++) m[en_pos(i)] = 1'b1;
    m[TMO_EN] = 1'b1;
    for (int i = 0; i < SCR_W; i++) m[i] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/msgirq_srcmap.sv
module msgirq_srcmap
  import msgirq_pkg::*;
#(
  parameter int N = NSRC
) (
  input  logic [31:0]  ctrl,
  input  logic [N-1:0] req,
  output logic [N-1:0] en_vec,
  output logic [N-1:0] masked
);
  for (genvar i = 0; i < N; i++) begin : g_src
    localparam int EP = en_pos(i);
    assign en_vec[i] = ctrl[EP];
    assign masked[i] = req[i] & ctrl[EP];
  end
endmodule

// File: rtl/msgirq_regs.sv
module msgirq_regs
  import msgirq_pkg::*;
#(
  parameter int REG_AW = 2,
  parameter int N      = NSRC
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [REG_AW-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              rd_valid,
  input  logic [N-1:0]      evt,
  input  logic [N-1:0]      masked,
  input  logic              msg_acked,
  input  logic              tmo_hit,
  output logic [31:0]       ctrl_q,
  output logic [N-1:0]      req_q,
  output logic              sent_q,
  output logic              tmo_flag_q,
  output logic              tmo_en,
  output logic              soft_rst,
  output logic [31:0]       tgt_addr,
  output logic [31:0]       payload
);
  localparam logic [31:0] WMASK = ctrl_wmask();

  logic          hit_ctrl, hit_stat, hit_taddr, hit_pload;
  logic [N-1:0]  w1c;
  logic [31:0]   ctrl_view, stat_view;

  assign hit_ctrl  = wr_en && (addr == REG_AW'(W_CTRL));
  assign hit_stat  = wr_en && (addr == REG_AW'(W_STAT));
  assign hit_taddr = wr_en && (addr == REG_AW'(W_TADDR));
  assign hit_pload = wr_en && (addr == REG_AW'(W_PLOAD));
  assign soft_rst  = hit_ctrl && wdata[SRST_BIT];
  assign w1c       = hit_stat ? wdata[REQ_LSB +: N] : '0;
  assign tmo_en    = ctrl_q[TMO_EN];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q   <= '0;
      tgt_addr <= '0;
      payload  <= '0;
    end else begin
      if (hit_ctrl)  ctrl_q   <= wdata & WMASK;
      if (hit_taddr) tgt_addr <= wdata;
      if (hit_pload) payload  <= wdata;
    end
  end

  // event set takes priority over write-1-to-clear
  always_ff @(posedge clk) begin
    if (rst || soft_rst) req_q <= '0;
    else                 req_q <= (req_q & ~w1c) | evt;
  end

  always_ff @(posedge clk) begin
    if (rst || soft_rst)  sent_q <= 1'b0;
    else if (msg_acked)   sent_q <= 1'b1;
    else if (masked == '0) sent_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst || soft_rst) tmo_flag_q <= 1'b0;
    else if (tmo_hit)    tmo_flag_q <= 1'b1;
  end

  always_comb begin
    ctrl_view           = ctrl_q & WMASK;
    ctrl_view[TMO_FLAG] = tmo_flag_q;
    stat_view                = '0;
    stat_view[REQ_LSB +: N]  = req_q;
    stat_view[SENT_BIT]      = sent_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata    <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) begin
        case (addr)
          REG_AW'(W_CTRL):  rdata <= ctrl_view;
          REG_AW'(W_STAT):  rdata <= stat_view;
          REG_AW'(W_TADDR): rdata <= tgt_addr;
          REG_AW'(W_PLOAD): rdata <= payload;
          default:          rdata <= '0;
        endcase
      end
    end
  end

  AST_TIMEOUT_STICKY: assert property (@(posedge clk) disable iff (rst)
    tmo_flag_q && !soft_rst |=> tmo_flag_q); // R9
  AST_SENT_NEEDS_ACK: assert property (@(posedge clk) disable iff (rst)
    $rose(sent_q) |-> $past(msg_acked)); // R6
  AST_SOFT_RST_CLEARS: assert property (@(posedge clk) disable iff (rst)
    soft_rst |=> (req_q == '0) && !sent_q && !tmo_flag_q); // R10
endmodule

// File: rtl/msgirq_sender.sv
module msgirq_sender
  import msgirq_pkg::*;
#(
  parameter int TMO_LIMIT = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        fire,
  input  logic [31:0] tgt_addr,
  input  logic [31:0] payload,
  input  logic        tmo_en,
  input  logic        soft_rst,
  input  logic        mw_ack,
  output logic        mw_valid,
  output logic [31:0] mw_addr,
  output logic [31:0] mw_data,
  output logic        msg_acked,
  output logic        tmo_hit
);
  localparam int CNT_W = $clog2(TMO_LIMIT + 1);

  snd_state_e       state;
  logic [CNT_W-1:0] wait_cnt;

  assign mw_valid  = (state == SND_WAIT);
  assign msg_acked = mw_valid && mw_ack;
  assign tmo_hit   = mw_valid && !mw_ack && tmo_en &&
                     (wait_cnt == CNT_W'(TMO_LIMIT - 1));

  always_ff @(posedge clk) begin
    if (rst || soft_rst) begin
      state    <= SND_IDLE;
      wait_cnt <= '0;
      mw_addr  <= '0;
      mw_data  <= '0;
    end else begin
      case (state)
        SND_IDLE: begin
          wait_cnt <= '0;
          if (fire) begin
            state   <= SND_WAIT;
            mw_addr <= tgt_addr;
            mw_data <= payload;
          end
        end
        SND_WAIT: begin
          if (mw_ack || tmo_hit) begin
            state    <= SND_IDLE;
            wait_cnt <= '0;
          end else if (tmo_en) begin
            wait_cnt <= wait_cnt + 1'b1;
          end
        end
        default: state <= SND_IDLE;
      endcase
    end
  end

  AST_HOLD_UNTIL_ACK: assert property (@(posedge clk) disable iff (rst)
    mw_valid && !mw_ack && !soft_rst && !tmo_hit |=>
      mw_valid && $stable(mw_addr) && $stable(mw_data)); // R5
  AST_DROP_AFTER_ACK: assert property (@(posedge clk) disable iff (rst)
    mw_valid && mw_ack |=> !mw_valid); // R5
  AST_TIMEOUT_DROPS: assert property (@(posedge clk) disable iff (rst)
    tmo_hit |=> !mw_valid); // R9
endmodule

// File: rtl/msgirq_ctrl.sv
module msgirq_ctrl
  import msgirq_pkg::*;
#(
  parameter int REG_AW    = 2,
  parameter int TMO_LIMIT = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr_en,
  input  logic              reg_rd_en,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              reg_rd_valid,
  input  logic [NSRC-1:0]   evt_req,
  output logic              mw_valid,
  output logic [31:0]       mw_addr,
  output logic [31:0]       mw_data,
  input  logic              mw_ack
);
  logic [31:0]     ctrl_q, tgt_addr, payload;
  logic [NSRC-1:0] req_q, en_vec, masked;
  logic            sent_q, tmo_flag_q, tmo_en, soft_rst;
  logic            msg_acked, tmo_hit, fire;

  msgirq_regs #(.REG_AW(REG_AW), .N(NSRC)) u_regs (
    .clk(clk), .rst(rst),
    .wr_en(reg_wr_en), .rd_en(reg_rd_en), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .rd_valid(reg_rd_valid),
    .evt(evt_req), .masked(masked), .msg_acked(msg_acked), .tmo_hit(tmo_hit),
    .ctrl_q(ctrl_q), .req_q(req_q), .sent_q(sent_q), .tmo_flag_q(tmo_flag_q),
    .tmo_en(tmo_en), .soft_rst(soft_rst), .tgt_addr(tgt_addr), .payload(payload)
  );

  msgirq_srcmap #(.N(NSRC)) u_map (
    .ctrl(ctrl_q), .req(req_q), .en_vec(en_vec), .masked(masked)
  );

  assign fire = (|masked) && !sent_q && !tmo_flag_q;

  msgirq_sender #(.TMO_LIMIT(TMO_LIMIT)) u_snd (
    .clk(clk), .rst(rst), .fire(fire), .tgt_addr(tgt_addr), .payload(payload),
    .tmo_en(tmo_en), .soft_rst(soft_rst), .mw_ack(mw_ack),
    .mw_valid(mw_valid), .mw_addr(mw_addr), .mw_data(mw_data),
    .msg_acked(msg_acked), .tmo_hit(tmo_hit)
  );

  AST_NO_ISSUE_WHILE_SENT: assert property (@(posedge clk) disable iff (rst)
    $rose(mw_valid) |-> !$past(sent_q)); // R6
  AST_NO_ISSUE_AFTER_TMO: assert property (@(posedge clk) disable iff (rst)
    $rose(mw_valid) |-> !$past(tmo_flag_q)); // R9
  AST_ISSUE_NEEDS_ENABLED: assert property (@(posedge clk) disable iff (rst)
    $rose(mw_valid) |-> $past((req_q & en_vec) != '0)); // R8
endmodule

// File: tb/test_msgirq_ctrl.sv
module test_msgirq_ctrl;
  localparam int TMO = 16;
  localparam logic [31:0] EN_BP = 32'h1 << 10;
  localparam logic [31:0] TCE   = 32'h1 << 12;
  localparam logic [31:0] EN_VB = 32'h1 << 26;
  localparam logic [31:0] EN_HW = 32'h1 << 29;
  localparam logic [31:0] SENT  = 32'h1 << 23;
  localparam logic [31:0] TFLG  = 32'h1 << 13;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr_en = 1'b0, reg_rd_en = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        reg_rd_valid;
  logic [7:0]  evt_req = '0;
  logic        mw_valid;
  logic [31:0] mw_addr, mw_data;
  logic        mw_ack = 1'b0;

  int checks = 0, errors = 0;
  int msg_cnt = 0, hi_cnt = 0, wait_cnt = 0, ack_delay = 0;
  bit ack_ena = 1'b1;
  bit done = 1'b0;
  logic [63:0] exp_q[$];
  logic [31:0] d;

  always #10 clk = ~clk;

  msgirq_ctrl #(.REG_AW(2), .TMO_LIMIT(TMO)) i_msgirq_ctrl (
    .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .reg_rd_valid(reg_rd_valid), .evt_req(evt_req), .mw_valid(mw_valid),
    .mw_addr(mw_addr), .mw_data(mw_data), .mw_ack(mw_ack)
  );

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] v);
    @(negedge clk); reg_wr_en = 1'b1; reg_addr = a; reg_wdata = v;
    @(negedge clk); reg_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    @(negedge clk); reg_rd_en = 1'b1; reg_addr = a;
    @(negedge clk); reg_rd_en = 1'b0; v = reg_rdata;
  endtask

  task automatic pulse(input int i);
    @(negedge clk); evt_req[i] = 1'b1;
    @(negedge clk); evt_req[i] = 1'b0;
  endtask

  task automatic expect_msg(input logic [31:0] a, input logic [31:0] p);
    exp_q.push_back({a, p});
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: acknowledges writes and compares against the scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (mw_ack) begin
        mw_ack = 1'b0;
        chk("R5 valid low after ack", {31'd0, mw_valid}, 32'd0);
      end else if (mw_valid) begin
        if (!ack_ena) hi_cnt++;
        else if (wait_cnt >= ack_delay) begin
          logic [63:0] e;
          mw_ack = 1'b1;
          wait_cnt = 0;
          msg_cnt++;
          checks++;
          if (exp_q.size() == 0) begin
            errors++;
            $display("FAIL R4 unexpected write actual=%h_%h expected=none", mw_addr, mw_data);
          end else begin
            e = exp_q.pop_front();
            if ({mw_addr, mw_data} !== e) begin
              errors++;
              $display("FAIL R4 message actual=%h_%h expected=%h_%h",
                       mw_addr, mw_data, e[63:32], e[31:0]);
            end
          end
        end else wait_cnt++;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst = 1'b0;
    idle(1);
    // R1 reset state
    chk("R1 mw_valid", {31'd0, mw_valid}, 32'd0);
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), d);
      chk("R1 reset word", d, 32'd0);
    end

    // R2 writable mask
    wr(2'd0, 32'hFFFF_FFFF);
    rd(2'd0, d); chk("R2 ctrl mask", d, 32'h3F00_1CFF);
    wr(2'd0, 32'd0);
    wr(2'd2, 32'h8000_1234);
    wr(2'd3, 32'hCAFE_0001);
    rd(2'd2, d); chk("R4 target address", d, 32'h8000_1234);
    rd(2'd3, d); chk("R4 payload", d, 32'hCAFE_0001);

    // R3/R4: vertical blank source (index 4, status bit 18, enable bit 26)
    wr(2'd0, EN_VB | 32'hA5);
    rd(2'd0, d); chk("R2 scratch and enable", d, EN_VB | 32'hA5);
    expect_msg(32'h8000_1234, 32'hCAFE_0001);
    pulse(4);
    idle(10);
    chk("R4 one write", msg_cnt, 1);
    rd(2'd1, d); chk("R3 R6 status after send", d, (32'h1 << 18) | SENT);

    // R6: no new write while sent is set
    wr(2'd0, EN_VB | EN_HW | 32'hA5);
    pulse(7);
    idle(10);
    chk("R6 blocked while sent", msg_cnt, 1);
    rd(2'd1, d); chk("R6 status", d, (32'h1 << 21) | (32'h1 << 18) | SENT);

    // R7: write-1-to-clear and re-arm
    wr(2'd1, 32'h1 << 18);
    idle(2);
    rd(2'd1, d); chk("R7 partial clear", d, (32'h1 << 21) | SENT);
    wr(2'd1, 32'h1 << 21);
    idle(2);
    rd(2'd1, d); chk("R7 sent cleared", d, 32'd0);
    wr(2'd3, 32'h1111_2222);
    expect_msg(32'h8000_1234, 32'h1111_2222);
    pulse(7);
    idle(10);
    chk("R7 new write after re-arm", msg_cnt, 2);
    wr(2'd1, 32'h1 << 21);
    idle(3);

    // R8: disabled source records but does not send
    pulse(0);
    idle(10);
    chk("R8 no write when disabled", msg_cnt, 2);
    rd(2'd1, d); chk("R8 request recorded", d, 32'h1 << 14);
    expect_msg(32'h8000_1234, 32'h1111_2222);
    wr(2'd0, EN_VB | EN_HW | EN_BP | 32'hA5);
    idle(10);
    chk("R4 late enable sends", msg_cnt, 3);
    wr(2'd1, 32'h003F_C000);
    idle(3);

    // R11: set wins over clear in the same cycle (source 5, not enabled)
    pulse(5);
    idle(2);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = 2'd1; reg_wdata = 32'h1 << 19; evt_req[5] = 1'b1;
    @(negedge clk);
    reg_wr_en = 1'b0; evt_req[5] = 1'b0;
    rd(2'd1, d); chk("R11 set wins", d, 32'h1 << 19);
    wr(2'd1, 32'h1 << 19);
    rd(2'd1, d); chk("R7 plain clear", d, 32'd0);

    // R5: slow acknowledge
    ack_delay = 7;
    wr(2'd3, 32'h3333_4444);
    expect_msg(32'h8000_1234, 32'h3333_4444);
    pulse(4);
    idle(25);
    chk("R5 slow ack write", msg_cnt, 4);
    ack_delay = 0;
    wr(2'd1, 32'h003F_C000);
    idle(3);

    // R9: timeout
    ack_ena = 1'b0;
    hi_cnt = 0;
    wr(2'd0, EN_VB | TCE | 32'hA5);
    pulse(4);
    idle(30);
    chk("R9 valid cycles", hi_cnt, TMO);
    chk("R9 valid dropped", {31'd0, mw_valid}, 32'd0);
    rd(2'd0, d); chk("R9 flag set", d, EN_VB | TCE | TFLG | 32'hA5);
    rd(2'd1, d); chk("R9 not sent", d, 32'h1 << 18);
    wr(2'd1, 32'h1 << 18);
    pulse(4);
    idle(10);
    chk("R9 locked out", hi_cnt, TMO);

    // R10: soft reset
    wr(2'd0, EN_VB | TCE | 32'hA5 | (32'h1 << 8));
    idle(2);
    rd(2'd0, d); chk("R10 ctrl after soft reset", d, EN_VB | TCE | 32'hA5);
    rd(2'd1, d); chk("R10 status cleared", d, 32'd0);
    rd(2'd2, d); chk("R10 address kept", d, 32'h8000_1234);
    rd(2'd3, d); chk("R10 payload kept", d, 32'h3333_4444);
    ack_ena = 1'b1;
    expect_msg(32'h8000_1234, 32'h3333_4444);
    pulse(4);
    idle(10);
    chk("R10 sends again", msg_cnt, 5);
    chk("R4 scoreboard drained", exp_q.size(), 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule